// File: doc/BRIEF.md
# Angle Tracking Loop Health and Resolution Supervisor

This block watches a digital angle-tracking loop, for example a resolver-to-digital converter, and reports on its health. Each clock it takes the loop's signed error word, counted in output LSBs, and it also takes three fault indications: missing input signal, missing reference carrier and excess tracking rate. From these it drives one registered health flag. The flag rests low. It rises when any fault is present or when the error magnitude goes above a fixed count of 180 LSBs of the active resolution. It drops again only after the loop has stayed clean for a programmable number of consecutive clocks.

The block also owns the converter's resolution mode, which is either 16-bit (fine) or 14-bit (coarse). A resolution-select input may change at any time. The block takes its value only when the converter's counter-busy strobe falls, so a mode change cannot cut into a count in progress. In coarse mode each LSB is four fine LSBs, so the error word is shifted right by two before it is compared. All asynchronous inputs (busy, select and the three fault flags) pass through a two-flop synchronizer before use.

Top module: `trk_health_mon`

## Requirements
- R1: While reset is high, on the next clock `health_flag` is 0 and `res_coarse` is 0 (16-bit mode).
- R2: In fine mode (`res_coarse` = 0), an error magnitude above 180 sets `health_flag` on the second rising edge after the error word is applied. A magnitude of exactly 180 leaves the flag at 0.
- R3: In coarse mode (`res_coarse` = 1), the magnitude is shifted right by 2 before the comparison against 180. A magnitude of 723 therefore leaves the flag at 0, and 724 sets it.
- R4: `loop_err` is two's complement and its absolute value is used. The most negative code (16'h8000) saturates to 32767 and sets the flag in either mode.
- R5: `sig_lost` high sets `health_flag` on the third rising edge after it is applied.
- R6: `ref_lost` high sets `health_flag` on the third rising edge after it is applied.
- R7: `rate_fault` high sets `health_flag` on the third rising edge after it is applied.
- R8: Once set, `health_flag` clears only after SETTLE_CYC consecutive clean clocks. A clean clock has no fault and the error within threshold. A fault during the count restarts it. With the default SETTLE_CYC = 4, the flag is still 1 four edges after the error returns within threshold, and 0 one edge later.
- R9: `res_coarse` takes the value of `res_sel` (1 = 14-bit, 0 = 16-bit) only on a falling edge of `busy`, and does so on the third rising edge after `busy` falls. A change of `res_sel` while `busy` is steady does not change `res_coarse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| loop_err | input | ERR_W | Signed loop error in output LSBs |
| sig_lost | input | 1 | Input signal missing (asynchronous) |
| ref_lost | input | 1 | Reference carrier missing (asynchronous) |
| rate_fault | input | 1 | Tracking rate exceeded (asynchronous) |
| res_sel | input | 1 | Requested resolution, 1 = 14-bit (asynchronous) |
| busy | input | 1 | Converter counter-busy strobe (asynchronous) |
| health_flag | output | 1 | Built-in-test flag, 1 = fault |
| res_coarse | output | 1 | Active resolution, 1 = 14-bit |

## Verification
The bench walks the threshold from both sides, at 180/181 in fine mode and at 723/724 in coarse mode, and repeats this for negative errors. A compare written as `>=`, or a coarse shift that is missing, would fail one side of each pair. Applying the most negative code catches an absolute value that wraps back to a negative number and misses the fault. A single error spike one edge before the settle count ends catches a counter that is not restarted, which would clear the flag early. Toggling `res_sel` while `busy` sits high or low catches a mode latch that follows the level instead of the falling edge.

// File: rtl/trk_pkg.sv
package trk_pkg;
   typedef enum logic {
      RES_FINE   = 1'b0,
      RES_COARSE = 1'b1
   } res_mode_t;

   // positions inside the synchronized status vector
   localparam int unsigned SB_RATE = 0;
   localparam int unsigned SB_REF  = 1;
   localparam int unsigned SB_SIG  = 2;
   localparam int unsigned SB_BUSY = 3;
   localparam int unsigned SB_SEL  = 4;
   localparam int unsigned SB_W    = 5;
endpackage

// File: rtl/trk_sync_chain.sv
module trk_sync_chain #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("trk_sync_chain: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) stage_q[gi] <= '0;
               else     stage_q[gi] <= din;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) stage_q[gi] <= '0;
               else     stage_q[gi] <= stage_q[gi-1];
            end
         end
      end
   endgenerate

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/trk_res_latch.sv
module trk_res_latch
   import trk_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  logic      busy_s,
   input  logic      sel_s,
   output res_mode_t mode,
   output logic      busy_fall
);
   logic busy_d;

   always_ff @(posedge clk) begin
      if (rst) busy_d <= 1'b0;
      else     busy_d <= busy_s;
   end

   assign busy_fall = busy_d & ~busy_s;

   always_ff @(posedge clk) begin
      if (rst)            mode <= RES_FINE;
      else if (busy_fall) mode <= res_mode_t'(sel_s);
   end

   AST_MODE_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (rst)
      !busy_fall |=> $stable(mode)); // R9
endmodule

// File: rtl/trk_err_cmp.sv
module trk_err_cmp
   import trk_pkg::*;
#(
   parameter int unsigned ERR_W        = 16,
   parameter int unsigned THRESH       = 180,
   parameter int unsigned COARSE_SHIFT = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ERR_W-1:0] err,
   input  res_mode_t        mode,
   output logic             over
);
   localparam logic [ERR_W-1:0] NEG_MIN = {1'b1, {(ERR_W-1){1'b0}}};
   localparam logic [ERR_W-1:0] POS_MAX = {1'b0, {(ERR_W-1){1'b1}}};
   localparam logic [ERR_W-1:0] LIMIT  = ERR_W'(THRESH);

   generate
      if (THRESH >= (1 << (ERR_W - 1))) begin : g_bad_thr
         $error("trk_err_cmp: THRESH does not fit the error width");
      end
      if (COARSE_SHIFT >= ERR_W) begin : g_bad_shift
         $error("trk_err_cmp: COARSE_SHIFT too large");
      end
   endgenerate

   logic [ERR_W-1:0] mag;
   logic [ERR_W-1:0] scaled;

   always_comb begin
      if (!err[ERR_W-1])     mag = err;
      else if (err == NEG_MIN) mag = POS_MAX;
      else                   mag = ~err + 1'b1;
   end

   assign scaled = (mode == RES_COARSE) ? (mag >> COARSE_SHIFT) : mag;

   always_ff @(posedge clk) begin
      if (rst) over <= 1'b0;
      else     over <= (scaled > LIMIT);
   end

   AST_NEG_MIN_FAULTS: assert property (@(posedge clk) disable iff (rst)
      (err == NEG_MIN) |=> over); // R4
   AST_ZERO_CLEAN: assert property (@(posedge clk) disable iff (rst)
      (err == '0) |=> !over); // R2
endmodule

// File: rtl/trk_flag_ctl.sv
module trk_flag_ctl #(
   parameter int unsigned SETTLE_CYC = 4
) (
   input  logic clk,
   input  logic rst,
   input  logic fault,
   output logic flag
);
   localparam int unsigned CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SETTLE_CYC - 1);

   generate
      if (SETTLE_CYC < 1) begin : g_bad
         $error("trk_flag_ctl: SETTLE_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] quiet_cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag      <= 1'b0;
         quiet_cnt <= '0;
      end else if (fault) begin
         flag      <= 1'b1;
         quiet_cnt <= '0;
      end else if (flag) begin
         if (quiet_cnt == CNT_LAST) begin
            flag      <= 1'b0;
            quiet_cnt <= '0;
         end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
         end
      end
   end

   AST_FAULT_SETS: assert property (@(posedge clk) disable iff (rst)
      fault |=> flag); // R5
   AST_CLEAR_AFTER_QUIET: assert property (@(posedge clk) disable iff (rst)
      $fell(flag) |-> $past(!fault)); // R8
   AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
      quiet_cnt <= CNT_LAST); // R8
endmodule

// File: rtl/trk_health_mon.sv
module trk_health_mon
   import trk_pkg::*;
#(
   parameter int unsigned ERR_W        = 16,
   parameter int unsigned THRESH       = 180,
   parameter int unsigned COARSE_SHIFT = 2,
   parameter int unsigned SETTLE_CYC   = 4,
   parameter int unsigned SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ERR_W-1:0] loop_err,
   input  logic             sig_lost,
   input  logic             ref_lost,
   input  logic             rate_fault,
   input  logic             res_sel,
   input  logic             busy,
   output logic             health_flag,
   output logic             res_coarse
);
   logic [SB_W-1:0] st_raw;
   logic [SB_W-1:0] st_s;
   res_mode_t       mode;
   logic            busy_fall;
   logic            err_over;
   logic            fault_any;

   always_comb begin
      st_raw          = '0;
      st_raw[SB_RATE] = rate_fault;
      st_raw[SB_REF]  = ref_lost;
      st_raw[SB_SIG]  = sig_lost;
      st_raw[SB_BUSY] = busy;
      st_raw[SB_SEL]  = res_sel;
   end

   trk_sync_chain #(.WIDTH(SB_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (st_raw),
      .dout(st_s)
   );

   trk_res_latch u_res (
      .clk      (clk),
      .rst      (rst),
      .busy_s   (st_s[SB_BUSY]),
      .sel_s    (st_s[SB_SEL]),
      .mode     (mode),
      .busy_fall(busy_fall)
   );

   trk_err_cmp #(
      .ERR_W       (ERR_W),
      .THRESH      (THRESH),
      .COARSE_SHIFT(COARSE_SHIFT)
   ) u_cmp (
      .clk (clk),
      .rst (rst),
      .err (loop_err),
      .mode(mode),
      .over(err_over)
   );

   assign fault_any = err_over | st_s[SB_SIG] | st_s[SB_REF] | st_s[SB_RATE];

   trk_flag_ctl #(.SETTLE_CYC(SETTLE_CYC)) u_flag (
      .clk  (clk),
      .rst  (rst),
      .fault(fault_any),
      .flag (health_flag)
   );

   assign res_coarse = (mode == RES_COARSE);

   AST_RES_NEEDS_FALL: assert property (@(posedge clk) disable iff (rst)
      (res_coarse != $past(res_coarse)) |-> $past(busy_fall)); // R9
   AST_SYNC_FAULT_FLAGS: assert property (@(posedge clk) disable iff (rst)
      (st_s[SB_SIG] | st_s[SB_REF] | st_s[SB_RATE]) |=> health_flag); // R6
endmodule

// File: tb/tb_trk_health_mon.sv
module tb_trk_health_mon;
   localparam int CLK_PERIOD = 10;
   localparam int SETTLE     = 4;
   localparam int WATCHDOG   = 20000;

   logic        clk = 1'b0;
   logic        rst;
   logic [15:0] loop_err;
   logic        sig_lost, ref_lost, rate_fault, res_sel, busy;
   logic        health_flag, res_coarse;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   trk_health_mon dut (
      .clk(clk), .rst(rst), .loop_err(loop_err),
      .sig_lost(sig_lost), .ref_lost(ref_lost), .rate_fault(rate_fault),
      .res_sel(res_sel), .busy(busy),
      .health_flag(health_flag), .res_coarse(res_coarse)
   );

   // {mode, expected flag, error word}
   localparam int NV = 12;
   localparam logic [17:0] VEC [NV] = '{
      {1'b0, 1'b0, 16'd180},
      {1'b0, 1'b1, 16'd181},
      {1'b0, 1'b0, 16'hFF4C},
      {1'b0, 1'b1, 16'hFF4B},
      {1'b0, 1'b0, 16'd0},
      {1'b0, 1'b1, 16'h8000},
      {1'b0, 1'b1, 16'h7FFF},
      {1'b1, 1'b0, 16'd723},
      {1'b1, 1'b1, 16'd724},
      {1'b1, 1'b0, 16'hFD2D},
      {1'b1, 1'b1, 16'hFD2C},
      {1'b1, 1'b1, 16'h8000}
   };

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic set_mode(input logic m);
      res_sel = m;
      step(3);
      busy = 1'b1;
      step(4);
      busy = 1'b0;
      step(4);
   endtask

   initial begin
      rst = 1'b1; loop_err = '0; sig_lost = 0; ref_lost = 0; rate_fault = 0;
      res_sel = 0; busy = 0;
      step(3);
      check("R1 flag", health_flag, 1'b0);
      check("R1 mode", res_coarse, 1'b0);
      rst = 1'b0;
      step(2);

      // table walk: R2 R3 R4
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][17] !== res_coarse) begin
            set_mode(VEC[i][17]);
            check("R9 mode", res_coarse, VEC[i][17]);
         end
         loop_err = VEC[i][15:0];
         step(2);
         check(VEC[i][17] ? "R3/R4 coarse" : "R2/R4 fine", health_flag, VEC[i][16]);
         loop_err = '0;
         step(SETTLE + 3);
      end

      set_mode(1'b0);
      check("R9 back to fine", res_coarse, 1'b0);

      // R5 R6 R7: status faults, three edges
      sig_lost = 1; step(2); check("R5 early", health_flag, 1'b0);
      step(1); check("R5", health_flag, 1'b1);
      sig_lost = 0; step(SETTLE + 4);
      ref_lost = 1; step(3); check("R6", health_flag, 1'b1);
      ref_lost = 0; step(SETTLE + 4); check("R6 clear", health_flag, 1'b0);
      rate_fault = 1; step(3); check("R7", health_flag, 1'b1);
      rate_fault = 0; step(SETTLE + 4); check("R7 clear", health_flag, 1'b0);

      // R8: settle count and restart
      loop_err = 16'd200; step(2); check("R8 set", health_flag, 1'b1);
      loop_err = '0; step(SETTLE); check("R8 hold", health_flag, 1'b1);
      step(1); check("R8 clear", health_flag, 1'b0);
      loop_err = 16'd200; step(2);
      loop_err = '0; step(SETTLE - 1);
      loop_err = 16'd200; step(1);
      loop_err = '0;
      check("R8 spike", health_flag, 1'b1);
      step(SETTLE); check("R8 restart hold", health_flag, 1'b1);
      step(1); check("R8 restart clear", health_flag, 1'b0);

      // R9: select ignored without a busy fall
      res_sel = 1; step(6); check("R9 idle low", res_coarse, 1'b0);
      busy = 1; step(6); check("R9 busy high", res_coarse, 1'b0);
      busy = 0; step(2); check("R9 before latch", res_coarse, 1'b0);
      step(1); check("R9 latched", res_coarse, 1'b1);
      busy = 1; step(3); res_sel = 0; step(5);
      check("R9 held while busy", res_coarse, 1'b1);
      busy = 0; step(4); check("R9 relatch fine", res_coarse, 1'b0);

      // R1: reset from a set state
      loop_err = 16'd500; res_sel = 1; busy = 1; step(4); busy = 0; step(4);
      rst = 1; step(1);
      check("R1 reset flag", health_flag, 1'b0);
      check("R1 reset mode", res_coarse, 1'b0);
      rst = 0; loop_err = '0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule